// File: doc/BRIEF.md
# Sound channel volume envelope

This block holds the 4-bit volume of one sound channel and moves it up or down by one step on a programmable number of envelope ticks. A 64 Hz strobe supplies the ticks. A 3-bit period field sets the number of ticks per step, from 1 to 7. A trigger strobe restarts the note: it loads the programmed starting volume and restarts the tick countdown.

The control word holds the starting volume, the direction and the period. Writing it while a note plays does not simply store new settings. It also nudges the live volume in a fixed way: it can add one, add two, or mirror the volume to sixteen minus itself. Software uses this to change loudness by hand during a note. A trigger that arrives just before a sequencer step that clocks the envelope makes the first countdown one tick longer.

All outputs are registered. When trigger, control write and tick arrive in the same cycle, trigger wins over the write, and the write wins over the tick.

Top module: `env_volume`

## Requirements
- R1: After reset the volume output is 0, the stored control word is all zero (starting volume 0, decrease, period 0), and automatic stepping is stopped.
- R2: A trigger sets the volume to the stored starting volume and turns automatic stepping on, one cycle later.
- R3: While stepping is on and the period p is 1 to 7, the volume changes by one every p ticks. The direction bit set to 1 means increase and 0 means decrease.
- R4: With a stored period of 0, ticks never change the volume.
- R5: A trigger loads the tick countdown with the period, or with 8 when the period is 0. Later reloads at a step use the same value. So after a period-0 trigger followed by a switch to a non-zero period, the first step comes on the 8th tick after the trigger.
- R6: A trigger while the next-step flag is 1 loads the countdown with one more than the value in R5. Only the first countdown after that trigger is longer.
- R7: A step that would take the volume below 0 or above 15 leaves it unchanged and stops automatic stepping until the next trigger. While stepping is stopped, ticks do not change the volume.
- R8: A control write without a trigger first adjusts the live volume. It adds 1 if the old period is 0 and stepping is on. Otherwise it adds 2 if the old direction is decrease. Otherwise the volume is left as it is.
- R9: If that write changes the direction bit, the volume then becomes 16 minus the value from R8.
- R10: Only the low 4 bits of the adjusted volume are kept: 15 plus 2 gives 1, and 16 minus 0 gives 0.
- R11: A trigger in the same cycle as a control write uses the newly written control word and makes no R8 adjustment. A tick in the same cycle as a control write or a trigger is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| env_tick | input | 1 | One-cycle envelope tick strobe (64 Hz) |
| env_next | input | 1 | 1 when the next sequencer step clocks the envelope |
| trig | input | 1 | One-cycle note trigger strobe |
| ctl_we | input | 1 | Control word write strobe |
| ctl_vol | input | 4 | Starting volume in the written control word |
| ctl_up | input | 1 | Direction in the written control word, 1 = increase |
| ctl_per | input | 3 | Period in the written control word |
| vol | output | 4 | Current volume |

## Verification
Every result is due in the cycle after the clock edge that samples the stimulus. This holds for a trigger load, a step caused by a tick, and a control-write adjustment. The bench drives inputs on the falling edge and holds them for one full cycle. It reads the volume on the next falling edge, half a cycle after the register updates. A behavioural model is updated on the same rising edges and compared with the output on every falling edge. The directed checks count ticks from the trigger, so the 8-tick reload and the one-tick-longer countdown are seen on exactly the expected tick and not on the one before.

// File: rtl/env_volume.sv
module env_volume #(
  parameter int VW = 4,
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          env_tick,
  input  logic          env_next,
  input  logic          trig,
  input  logic          ctl_we,
  input  logic [VW-1:0] ctl_vol,
  input  logic          ctl_up,
  input  logic [PW-1:0] ctl_per,
  output logic [VW-1:0] vol
);
  localparam int TW = $clog2((2 ** PW) + 2);
  localparam int VMAX = (2 ** VW) - 1;

  logic [VW-1:0] cfg_vol;
  logic          cfg_up;
  logic [PW-1:0] cfg_per;
  logic [TW-1:0] tmr;
  logic          run;

  wire [VW-1:0] eff_vol = ctl_we ? ctl_vol : cfg_vol;
  wire [PW-1:0] eff_per = ctl_we ? ctl_per : cfg_per;
  wire [TW-1:0] trig_load = ((eff_per == '0) ? TW'(2 ** PW) : TW'(eff_per)) + TW'(env_next);
  wire [TW-1:0] cur_load  = (cfg_per == '0) ? TW'(2 ** PW) : TW'(cfg_per);
  wire          at_top = (vol == VW'(VMAX));
  wire          at_bot = (vol == '0);

  logic [VW:0] z_sum;
  logic [VW:0] z_new;
  always_comb begin
    z_sum = {1'b0, vol};
    if (cfg_per == '0 && run) z_sum = z_sum + (VW+1)'(1);
    else if (!cfg_up)         z_sum = z_sum + (VW+1)'(2);
    z_new = (ctl_up != cfg_up) ? (VW+1)'(2 ** VW) - z_sum : z_sum;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_vol <= '0;
      cfg_up  <= 1'b0;
      cfg_per <= '0;
      vol     <= '0;
      tmr     <= TW'(2 ** PW);
      run     <= 1'b0;
    end else if (trig) begin
      if (ctl_we) begin
        cfg_vol <= ctl_vol;
        cfg_up  <= ctl_up;
        cfg_per <= ctl_per;
      end
      vol <= eff_vol;
      tmr <= trig_load;
      run <= 1'b1;
    end else if (ctl_we) begin
      cfg_vol <= ctl_vol;
      cfg_up  <= ctl_up;
      cfg_per <= ctl_per;
      vol     <= z_new[VW-1:0];
    end else if (env_tick && run) begin
      if (tmr <= TW'(1)) begin
        tmr <= cur_load;
        if (cfg_per != '0) begin
          if (cfg_up) begin
            if (at_top) run <= 1'b0;
            else        vol <= vol + VW'(1);
          end else begin
            if (at_bot) run <= 1'b0;
            else        vol <= vol - VW'(1);
          end
        end
      end else begin
        tmr <= tmr - TW'(1);
      end
    end
  end

  a_r2_trig_loads: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> vol == $past(ctl_we ? ctl_vol : cfg_vol));
  a_r2_trig_runs: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> run);
  a_r3_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && !ctl_we) |=> (vol == $past(vol) || vol == $past(vol) + VW'(1) || vol == $past(vol) - VW'(1)));
  a_r4_per0_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && !ctl_we && cfg_per == '0) |=> $stable(vol));
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !trig && !ctl_we) |=> $stable(vol));
  a_r7_stop_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !trig) |=> !run);
endmodule

// File: tb/test_env_volume.sv
module test_env_volume;
  logic clk = 0, rst_n = 0;
  logic env_tick = 0, env_next = 0, trig = 0, ctl_we = 0, ctl_up = 0;
  logic [3:0] ctl_vol = 0;
  logic [2:0] ctl_per = 0;
  logic [3:0] vol;
  int checks = 0, failures = 0;
  bit done = 0;

  env_volume i_env_volume (.clk(clk), .rst_n(rst_n), .env_tick(env_tick), .env_next(env_next),
    .trig(trig), .ctl_we(ctl_we), .ctl_vol(ctl_vol), .ctl_up(ctl_up), .ctl_per(ctl_per), .vol(vol));

  always #2 clk = ~clk;

  int m_vol, m_tmr, m_run, m_cv, m_up, m_per;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_vol = 0; m_tmr = 8; m_run = 0; m_cv = 0; m_up = 0; m_per = 0;
    end else if (trig) begin
      if (ctl_we) begin m_cv = ctl_vol; m_up = ctl_up; m_per = ctl_per; end
      m_vol = m_cv;
      m_tmr = (m_per == 0 ? 8 : m_per) + (env_next ? 1 : 0);
      m_run = 1;
    end else if (ctl_we) begin
      int v;
      v = m_vol;
      if (m_per == 0 && m_run == 1) v = v + 1;
      else if (m_up == 0) v = v + 2;
      if (ctl_up != m_up) v = 16 - v;
      m_vol = v & 15;
      m_cv = ctl_vol; m_up = ctl_up; m_per = ctl_per;
    end else if (env_tick && m_run == 1) begin
      if (m_tmr <= 1) begin
        m_tmr = (m_per == 0) ? 8 : m_per;
        if (m_per != 0) begin
          if (m_up == 1) begin if (m_vol < 15) m_vol++; else m_run = 0; end
          else begin if (m_vol > 0) m_vol--; else m_run = 0; end
        end
      end else m_tmr--;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    checks++;
    if (int'(vol) != m_vol) begin
      failures++;
      $display("FAIL model: vol actual=%0d expected=%0d", vol, m_vol);
    end
  end

  task automatic chk(input string tag, input int exp);
    checks++;
    if (int'(vol) != exp) begin
      failures++;
      $display("FAIL %s: vol actual=%0d expected=%0d", tag, vol, exp);
    end
  endtask

  task automatic setcfg(input int v, input int up, input int p);
    @(negedge clk); ctl_we = 1; ctl_vol = 4'(v); ctl_up = up[0]; ctl_per = 3'(p);
    @(negedge clk); ctl_we = 0;
  endtask

  task automatic trigger(input bit nx);
    @(negedge clk); trig = 1; env_next = nx;
    @(negedge clk); trig = 0; env_next = 0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); env_tick = 1;
      @(negedge clk); env_tick = 0;
    end
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset", 0);
    tick(3); chk("R1 stopped after reset", 0);

    setcfg(5, 1, 2); trigger(0); chk("R2 trigger load", 5);
    tick(1); chk("R3 before step", 5);
    tick(1); chk("R3 first step", 6);
    tick(2); chk("R3 second step", 7);

    setcfg(9, 1, 0); trigger(0); tick(20); chk("R4 period zero holds", 9);

    setcfg(3, 1, 0); trigger(0); tick(3);
    setcfg(3, 1, 1); chk("R8 plus one", 4);
    tick(4); chk("R5 reload of 8 not yet", 4);
    tick(1); chk("R5 reload of 8 step", 5);

    setcfg(4, 0, 2); trigger(1); tick(2); chk("R6 longer first count", 4);
    tick(1); chk("R6 step after extra tick", 3);
    tick(2); chk("R6 normal reload after", 2);

    setcfg(1, 0, 1); trigger(0); tick(1); chk("R3 down to zero", 0);
    tick(1); chk("R7 floor", 0);
    setcfg(1, 0, 1); chk("R8 plus two", 2);
    tick(5); chk("R7 stepping stopped", 2);
    trigger(0); tick(1); chk("R7 trigger restarts", 0);

    setcfg(14, 1, 1); trigger(0); tick(2); chk("R7 ceiling", 15);
    setcfg(14, 1, 0); chk("R8 old up nonzero period no change", 15);
    setcfg(14, 1, 0); chk("R8 period zero but stopped", 15);

    setcfg(5, 0, 3); trigger(0);
    setcfg(5, 1, 3); chk("R9 down to up mirror", 9);
    tick(3); chk("R9 new direction steps", 10);
    setcfg(6, 1, 2); trigger(0);
    setcfg(6, 0, 2); chk("R9 up to down mirror", 10);

    setcfg(15, 0, 1); trigger(0);
    setcfg(15, 0, 1); chk("R10 wrap of plus two", 1);
    setcfg(0, 1, 3); trigger(0);
    setcfg(0, 0, 3); chk("R10 sixteen minus zero", 0);

    setcfg(2, 0, 1); trigger(0);
    @(negedge clk); trig = 1; ctl_we = 1; ctl_vol = 7; ctl_up = 1; ctl_per = 2;
    @(negedge clk); trig = 0; ctl_we = 0;
    chk("R11 trigger with write", 7);
    @(negedge clk); env_tick = 1; ctl_we = 1; ctl_vol = 7; ctl_up = 1; ctl_per = 2;
    @(negedge clk); env_tick = 0; ctl_we = 0;
    chk("R11 write with tick", 7);
    tick(1); chk("R11 tick ignored", 7);
    tick(1); chk("R11 step after", 8);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule